// File: doc/BRIEF.md
# Sliding-Window Idle Slot Enforcer

This block sits between a memory user and the user port of a banked dynamic memory. The memory needs idle timeslots so that its refresh logic can work, and the block makes sure those slots appear. Every timeslot, the user may present a request. The block grants it, or holds it off with a stall, so that any run of `WIN_LEN` consecutive timeslots holds at least `IDLE_MIN` idle-equivalent slots. The rule applies at every starting slot, not only inside fixed aligned frames. A user may therefore issue up to `WIN_LEN - IDLE_MIN` back-to-back accesses, and in the worst case it gives up a share of `IDLE_MIN / WIN_LEN` of the bandwidth.

When the refresh scheduler reports a no-conflict slot, the bank it wants to refresh is not the one being accessed. The block grants the request in such a slot and also counts the slot as idle-equivalent. An idle-equivalent slot is one with no grant (no request, or a stalled request) or one carrying this credit. Internally, the block keeps the slot stamps of the last `IDLE_MIN` idle-equivalent slots in a ring, driven by a free-running wrapping slot counter. It grants a credit-less request only if the oldest of those stamps is still inside the window that ends at the current slot. After reset, the block behaves as if `IDLE_MIN` idle slots had just taken place.

Top module: `idle_window_enforcer`

## Requirements
- R1: `stall` is high exactly in the slots where `reqValid` is high and `grant` is low, and `grant` is never high without `reqValid`.
- R2: After reset release, under back-to-back requests with no credit, the first `WIN_LEN - IDLE_MIN` requests are granted and the next one is stalled.
- R3: Counting `IDLE_MIN` idle-equivalent slots just before reset release, every window of `WIN_LEN` consecutive slots holds at least `IDLE_MIN` idle-equivalent slots. A slot is idle-equivalent when `grant` is low, or when `noConflict` is high.
- R4: A request in a slot with `noConflict` low is granted if, and only if, the preceding `WIN_LEN - 1` slots hold at least `IDLE_MIN` idle-equivalent slots.
- R5: A request in a slot with `noConflict` high is always granted, and that slot counts as idle-equivalent.
- R6: No run of consecutive slots granted with `noConflict` low is longer than `WIN_LEN - IDLE_MIN`.
- R7: A stalled slot counts as idle-equivalent, so the window that ends at a later slot gains from it.
- R8: Behaviour does not depend on how many slots have gone by since reset; it is the same after the internal slot counter has wrapped many times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one timeslot per rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | The user wants an access in the current slot |
| noConflict | input | 1 | Credit from the refresh scheduler: the current slot counts as idle-equivalent |
| grant | output | 1 | The access in the current slot may proceed |
| stall | output | 1 | The request in the current slot is held off and the slot is forced idle |

## Verification
A behavioural window model in the bench is compared with `grant` and `stall` in every slot, over several patterns. Unbroken credit-less requests measure the burst length and the stall spacing when the block is saturated. Sparse and mixed random requests tell whether earlier idle slots are aged out at the right slot. Requests that all carry credit show that the credit is both granted and counted as idle. Long runs spanning many counter wraps would show any wrap-compare fault. A separate window count over the observed outputs, together with a run-length count, checks R3 and R6 without relying on the model.

// File: rtl/idle_window_pkg.sv
package idle_window_pkg;

  // Per-slot strobes from the control to the datapath
  typedef struct packed {
    logic pushIdle;   // slot is idle-equivalent: record its stamp
    logic forced;     // slot was made idle by a stall
  } slotStrobe_t;

  function automatic int stampWidth(input int winLen);
    return $clog2(winLen + 1) + 1;
  endfunction

endpackage

// File: rtl/idle_window_dp.sv
module idle_window_dp
  import idle_window_pkg::*;
#(
  parameter int IDLE_MIN = 4,
  parameter int WIN_LEN  = 64,
  parameter int TS_W     = stampWidth(WIN_LEN)
) (
  input  logic        clk,
  input  logic        rstN,
  input  slotStrobe_t strobes,
  output logic        ageOk
);

  localparam int HEAD_W = (IDLE_MIN > 1) ? $clog2(IDLE_MIN) : 1;
  localparam logic [HEAD_W-1:0] HEAD_LAST = HEAD_W'(IDLE_MIN - 1);
  localparam logic [TS_W-1:0]   WIN_TS    = TS_W'(WIN_LEN);

  logic [TS_W-1:0]   slotCnt;
  logic [HEAD_W-1:0] headPtr;
  logic [TS_W-1:0]   stamps [IDLE_MIN];
  logic [TS_W-1:0]   oldestStamp;
  logic [TS_W-1:0]   age;

  // free-running slot counter, wraps freely
  always_ff @(posedge clk) begin
    if (!rstN) slotCnt <= '0;
    else       slotCnt <= slotCnt + TS_W'(1);
  end

  // ring pointer to the oldest stored stamp
  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr <= '0;
    end else if (strobes.pushIdle) begin
      if (headPtr == HEAD_LAST) headPtr <= '0;
      else                      headPtr <= headPtr + HEAD_W'(1);
    end
  end

  // one register per ring entry; reset preloads stamps -IDLE_MIN .. -1
  for (genvar g = 0; g < IDLE_MIN; g++) begin : g_entry
    localparam logic [TS_W-1:0] PRELOAD = TS_W'((1 << TS_W) - IDLE_MIN + g);
    always_ff @(posedge clk) begin
      if (!rstN)
        stamps[g] <= PRELOAD;
      else if (strobes.pushIdle && (headPtr == HEAD_W'(g)))
        stamps[g] <= slotCnt;
    end
  end

  assign oldestStamp = stamps[headPtr];
  assign age         = slotCnt - oldestStamp;   // modular distance
  assign ageOk       = (age < WIN_TS);

  // R3: the oldest recorded idle never falls further back than one window
  p_age_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    age <= WIN_TS);

  // R6: a slot that records nothing makes the oldest stamp one slot older
  p_age_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && !strobes.pushIdle) |=> age == $past(age) + TS_W'(1));

  // R7: a forced slot always pushes a stamp, moving the oldest pointer on
  p_forced_push_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.forced && IDLE_MIN > 1) |=> headPtr != $past(headPtr));

endmodule

// File: rtl/idle_window_ctrl.sv
module idle_window_ctrl
  import idle_window_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        noConflict,
  input  logic        ageOk,
  output logic        grant,
  output logic        stall,
  output slotStrobe_t strobes
);

  always_comb begin
    grant            = reqValid && (noConflict || ageOk);
    stall            = reqValid && !grant;
    strobes.pushIdle = !grant || noConflict;
    strobes.forced   = stall;
  end

  // R1: a stall only ever holds off a pending request
  p_stall_req_r1: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> (reqValid && !grant));

  // R1: no grant without a request
  p_grant_req_r1: assert property (@(posedge clk) disable iff (!rstN)
    grant |-> reqValid);

  // R5: credited requests go through
  p_credit_grant_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && noConflict) |-> grant);

endmodule

// File: rtl/idle_window_enforcer.sv
module idle_window_enforcer
  import idle_window_pkg::*;
#(
  parameter int IDLE_MIN = 4,
  parameter int WIN_LEN  = 64
) (
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  input  logic noConflict,
  output logic grant,
  output logic stall
);

  localparam int TS_W = stampWidth(WIN_LEN);

  slotStrobe_t strobes;
  logic        ageOk;

  idle_window_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .noConflict (noConflict),
    .ageOk      (ageOk),
    .grant      (grant),
    .stall      (stall),
    .strobes    (strobes)
  );

  idle_window_dp #(
    .IDLE_MIN (IDLE_MIN),
    .WIN_LEN  (WIN_LEN),
    .TS_W     (TS_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .ageOk   (ageOk)
  );

  initial begin
    a_params_r2: assert (IDLE_MIN >= 1 && IDLE_MIN < WIN_LEN);
  end

endmodule

// File: tb/idle_window_enforcer_bench.sv
module idle_window_enforcer_bench;

  localparam int X = 3;
  localparam int Y = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic noConflict = 1'b0;
  logic grant, stall;

  int testsRun = 0;
  int testsFailed = 0;
  int hist[$];      // model idle-equivalent history, last Y-1 slots
  int obs[$];       // observed idle-equivalent history, last Y-1 slots
  int runLen = 0;
  int lastStall = 0;
  string grantTag = "R4";

  always #10 clk = ~clk;   // 50 MHz

  idle_window_enforcer #(.IDLE_MIN(X), .WIN_LEN(Y)) u_idle_window_enforcer (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .noConflict(noConflict),
    .grant(grant), .stall(stall)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  function automatic int sumQ(input int q[$]);
    int s = 0;
    foreach (q[i]) s += q[i];
    return s;
  endfunction

  // one timeslot; returns the observed grant
  task automatic step(input bit req, input bit nc, output bit g);
    int cnt, expG, expS, actIdle;
    reqValid = req;
    noConflict = nc;
    #5;
    cnt  = sumQ(hist);
    expG = (req && (nc || cnt >= X)) ? 1 : 0;
    expS = (req && !expG) ? 1 : 0;
    if (nc) check(grant == expG, "R5 grant", grant, expG);
    else if (lastStall) check(grant == expG, "R7 grant", grant, expG);
    else check(grant == expG, grantTag, grant, expG);
    check(stall == expS, "R1 stall", stall, expS);
    actIdle = (!grant || nc) ? 1 : 0;
    check(sumQ(obs) + actIdle >= X, "R3 window", sumQ(obs) + actIdle, X);
    if (grant && !nc) runLen++; else runLen = 0;
    check(runLen <= Y - X, "R6 run", runLen, Y - X);
    hist.push_back((!expG || nc) ? 1 : 0); void'(hist.pop_front());
    obs.push_back(actIdle); void'(obs.pop_front());
    lastStall = stall;
    g = grant;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    testsFailed++;
    testsRun++;
    $display("FAIL watchdog: actual 1 expected 0");
    finishRun();
  end

  initial begin
    bit g;
    int firstGrants;
    bit seenStall;
    for (int i = 0; i < Y - 1; i++) begin
      hist.push_back(i >= Y - 1 - X ? 1 : 0);
      obs.push_back(i >= Y - 1 - X ? 1 : 0);
    end
    repeat (3) @(negedge clk);
    reqValid = 1'b1;
    #2;
    check(stall == 0 || grant == 1, "R1 reset", stall, 0);
    reqValid = 1'b0;
    #1;
    check(grant == 0 && stall == 0, "R1 reset idle", grant + stall, 0);
    rstN = 1'b1;

    // R2: saturated credit-less burst from reset
    grantTag = "R2";
    firstGrants = 0;
    seenStall = 0;
    for (int i = 0; i < 40; i++) begin
      step(1, 0, g);
      if (!seenStall && g) firstGrants++;
      if (!g) seenStall = 1;
    end
    check(firstGrants == Y - X, "R2 burst", firstGrants, Y - X);

    // sparse requests
    grantTag = "R4";
    for (int i = 0; i < 60; i++) step((i % 3) != 0, 0, g);
    for (int i = 0; i < 15; i++) step(0, 0, g);

    // all credited requests
    for (int i = 0; i < 40; i++) step(1, 1, g);

    // mixed random traffic over many counter wraps
    grantTag = "R8";
    for (int i = 0; i < 600; i++) step(($urandom % 4) != 0, ($urandom % 5) == 0, g);

    // saturated again after wraps
    for (int i = 0; i < 80; i++) step(1, 0, g);
    grantTag = "R4";
    for (int i = 0; i < 60; i++) step(($urandom % 2) == 0, 0, g);

    finishRun();
  end

endmodule